// File: doc/BRIEF.md
# Two-Stage Lane Multiplexing Store

This block merges four data lanes into one output word through two layers of storage. Every lane has its own first-stage cell. A cell either passes its lane through while the lane's hold-release enable is high, or takes a snapshot of the lane on a rising edge of a shared capture clock. A two-bit selector picks one first-stage cell and places its value on an internal node. A single second-stage cell then either passes that node through or takes its own snapshot on the same capture clock. The second-stage value reaches the output pins through an active-low output enable.

The capture clock is not used as a clock. The system clock samples it, and a low-to-high change between two samples counts as one capture edge. The high-impedance output state is represented by a drive flag that is low, with the data bits forced to zero. Each storage cell is a register on the system clock. A transparent cell therefore follows its source one system-clock cycle later. Because both stages update on the same edge, a capture edge moves the new lane value into the first stage while the second stage takes the value that the first stage held before that edge.

Top module: `tsm_mux_store`

## Requirements
- R1: While `lane_le[i]` is high, first-stage cell i takes `lane_data[i*WIDTH +: WIDTH]` on every system-clock edge. No other lane's cell is affected.
- R2: When `lane_le[i]` is low, `s1_ce_n` is low and a capture edge is detected, first-stage cell i loads its lane.
- R3: While `s1_ce_n` is high, a capture edge leaves the first-stage cells whose `lane_le` bit is low unchanged.
- R4: `sel` code 0 routes lane 0 to the internal node, code 1 routes lane 1, code 2 routes lane 2 and code 3 routes lane 3.
- R5: While `s2_le` is high, the second stage takes the internal node on every system-clock edge.
- R6: When `s2_le` is low, the second stage loads the internal node on a capture edge only if `s2_ce_n` is low. When `s2_ce_n` is high, it holds its value.
- R7: When `oe_n` is high, `out_en` is 0 and `out_data` is all zeros. When `oe_n` is low, `out_en` is 1 and `out_data` equals the second-stage value, with no added delay.
- R8: A capture edge is one system-clock cycle in which `cap_clk` is sampled high after being sampled low. Holding `cap_clk` high produces no further loads.
- R9: A synchronous reset (`rst` high at a system-clock edge) clears every first-stage cell and the second stage to zero. `cap_clk` held high through reset yields no capture edge.
- R10: On one capture edge that loads both stages, the second stage receives the selected first-stage value from before that edge, not the newly loaded lane value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_clk | input | 1 | Shared capture clock, sampled on clk |
| lane_data | input | LANES*WIDTH | Lane words, lane i in bits i*WIDTH +: WIDTH |
| lane_le | input | LANES | Per-lane pass-through enable for the first stage |
| s1_ce_n | input | 1 | First-stage capture enable, active low |
| sel | input | SEL_W | Lane selector feeding the internal node |
| s2_le | input | 1 | Second-stage pass-through enable |
| s2_ce_n | input | 1 | Second-stage capture enable, active low |
| oe_n | input | 1 | Output enable, active low |
| out_data | output | WIDTH | Output word, zero while not driven |
| out_en | output | 1 | Output drive flag, high when driving |

## Verification
The bench sweeps all four selector codes against several lane patterns whose lanes all hold different values. A misrouted selector code or a swapped lane therefore shows up as a wrong word. Enabling one lane at a time for pass-through separates per-lane enables from a shared enable. Capture-edge sequences are tried with the clock enables high, then low, then with `cap_clk` held high. These separate edge detection from level sensitivity and separate loading from holding. A single edge that loads both stages at once shows whether the second stage takes the old first-stage value or the new one.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_FOLLOW = 2'd1,
        ACT_LOAD   = 2'd2
    } store_act_e;

    // A cell follows while its enable is high; otherwise an active-low
    // clock enable lets a detected capture edge load it.
    function automatic store_act_e pick_action(input logic le,
                                               input logic ce_n,
                                               input logic rise);
        if (le)
            return ACT_FOLLOW;
        else if (!ce_n && rise)
            return ACT_LOAD;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tsm_cap_edge.sv
module tsm_cap_edge (
    input  logic clk,
    input  logic rst,
    input  logic cap_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    // While in reset the sampler tracks the input, so a level that is
    // already high when reset ends is not taken as an edge.
    always_comb begin
        st_d      = st_q;
        st_d.prev = cap_in;
        rise      = !rst && cap_in && !st_q.prev;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/tsm_store_cell.sv
module tsm_store_cell
    import tsm_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             le,
    input  logic             ce_n,
    input  logic             rise,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] val;
    } cell_st_t;

    cell_st_t   st_d, st_q;
    store_act_e act;

    always_comb begin
        st_d = st_q;
        act  = pick_action(le, ce_n, rise);
        unique case (act)
            ACT_FOLLOW, ACT_LOAD: st_d.val = din;
            default:              st_d.val = st_q.val;
        endcase
        if (rst)
            st_d.val = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/tsm_lane_select.sv
module tsm_lane_select #(
    parameter int WIDTH = 4,
    parameter int LANES = 4,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*WIDTH-1:0] lanes,
    input  logic [SEL_W-1:0]       sel,
    output logic [WIDTH-1:0]       node
);
    always_comb begin
        node = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i))
                node = lanes[i*WIDTH +: WIDTH];
        end
    end
endmodule

// File: rtl/tsm_mux_store.sv
module tsm_mux_store #(
    parameter int WIDTH = 4,
    parameter int LANES = 4,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap_clk,
    input  logic [LANES*WIDTH-1:0] lane_data,
    input  logic [LANES-1:0]       lane_le,
    input  logic                   s1_ce_n,
    input  logic [SEL_W-1:0]       sel,
    input  logic                   s2_le,
    input  logic                   s2_ce_n,
    input  logic                   oe_n,
    output logic [WIDTH-1:0]       out_data,
    output logic                   out_en
);
    logic                   cap_rise;
    logic [LANES*WIDTH-1:0] s1_flat;
    logic [WIDTH-1:0]       node;
    logic [WIDTH-1:0]       s2_val;

    tsm_cap_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cap_in (cap_clk),
        .rise   (cap_rise)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tsm_store_cell #(.WIDTH(WIDTH)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .le   (lane_le[g]),
            .ce_n (s1_ce_n),
            .rise (cap_rise),
            .din  (lane_data[g*WIDTH +: WIDTH]),
            .q    (s1_flat[g*WIDTH +: WIDTH])
        );
    end

    tsm_lane_select #(.WIDTH(WIDTH), .LANES(LANES)) u_sel (
        .lanes (s1_flat),
        .sel   (sel),
        .node  (node)
    );

    tsm_store_cell #(.WIDTH(WIDTH)) u_out_cell (
        .clk  (clk),
        .rst  (rst),
        .le   (s2_le),
        .ce_n (s2_ce_n),
        .rise (cap_rise),
        .din  (node),
        .q    (s2_val)
    );

    // Three-state pins: a drive flag plus data forced low while released.
    always_comb begin
        out_en   = !oe_n;
        out_data = oe_n ? '0 : s2_val;
    end
endmodule

// File: rtl/tsm_mux_store_chk.sv
module tsm_mux_store_chk #(
    parameter int WIDTH = 4,
    parameter int LANES = 4,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [LANES*WIDTH-1:0] lane_data,
    input logic [LANES-1:0]       lane_le,
    input logic                   s1_ce_n,
    input logic [SEL_W-1:0]       sel,
    input logic                   s2_le,
    input logic                   s2_ce_n,
    input logic                   oe_n,
    input logic [WIDTH-1:0]       out_data,
    input logic                   out_en,
    input logic [LANES*WIDTH-1:0] s1_flat,
    input logic [WIDTH-1:0]       node,
    input logic [WIDTH-1:0]       s2_val
);
    AST_ALL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (&lane_le) |=> s1_flat == $past(lane_data)); // R1

    AST_S1_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s1_ce_n && lane_le == '0) |=> $stable(s1_flat)); // R3

    AST_S2_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        s2_le |=> s2_val == $past(node)); // R5

    AST_S2_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!s2_le && s2_ce_n) |=> $stable(s2_val)); // R6

    AST_OUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!out_en && out_data == '0)); // R7

    AST_OUT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (out_en && out_data == s2_val)); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (s2_val == '0 && s1_flat == '0)); // R9

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(sel) < LANES) |-> node == s1_flat[sel*WIDTH +: WIDTH]); // R4
endmodule

bind tsm_mux_store tsm_mux_store_chk #(.WIDTH(WIDTH), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lane_data (lane_data),
    .lane_le   (lane_le),
    .s1_ce_n   (s1_ce_n),
    .sel       (sel),
    .s2_le     (s2_le),
    .s2_ce_n   (s2_ce_n),
    .oe_n      (oe_n),
    .out_data  (out_data),
    .out_en    (out_en),
    .s1_flat   (s1_flat),
    .node      (node),
    .s2_val    (s2_val)
);

// File: tb/tsm_mux_store_test.sv
`timescale 1ns/1ps
module tsm_mux_store_test;
    localparam int W = 4;
    localparam int L = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           cap_clk;
    logic [L*W-1:0] lane_data;
    logic [L-1:0]   lane_le;
    logic           s1_ce_n;
    logic [1:0]     sel;
    logic           s2_le;
    logic           s2_ce_n;
    logic           oe_n;
    logic [W-1:0]   out_data;
    logic           out_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tsm_mux_store #(.WIDTH(W), .LANES(L)) uut (
        .clk(clk), .rst(rst), .cap_clk(cap_clk), .lane_data(lane_data),
        .lane_le(lane_le), .s1_ce_n(s1_ce_n), .sel(sel), .s2_le(s2_le),
        .s2_ce_n(s2_ce_n), .oe_n(oe_n), .out_data(out_data), .out_en(out_en)
    );

    // Pattern p gives each lane a distinct value (lane*5 mod 16 differs).
    function automatic logic [W-1:0] pat(input int p, input int lane);
        return W'((p * 7 + lane * 5 + 3) % 16);
    endfunction

    function automatic logic [L*W-1:0] pack(input int p);
        logic [L*W-1:0] v;
        for (int i = 0; i < L; i++) v[i*W +: W] = pat(p, i);
        return v;
    endfunction

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Route lane j to the output through a following second stage.
    task automatic view(input int j);
        sel = 2'(j);
        tick(1);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cap_clk = 1'b0; lane_data = pack(1); lane_le = '1;
        s1_ce_n = 1'b1; sel = 2'd0; s2_le = 1'b1; s2_ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        tick(2);
        rst = 1'b0;
        lane_le = '0;
        tick(1);
        // R9: cleared state after reset
        check("R9 reset output", out_data, '0);
        check_bit("R9 reset drive", out_en, 1'b1);

        // R1 R4 R5: sweep every selector code across several patterns
        lane_le = '1;
        for (int p = 0; p < 4; p++) begin
            lane_data = pack(p);
            tick(2);
            for (int j = 0; j < L; j++) begin
                view(j);
                check($sformatf("R4 sel %0d pattern %0d", j, p), out_data, pat(p, j));
            end
        end
        // state: stage 1 holds pattern 3

        // R3: no edge and clock enable high -> lanes ignored
        lane_le = '0; s1_ce_n = 1'b1; cap_clk = 1'b0;
        tick(1);
        lane_data = pack(5);
        tick(2);
        cap_clk = 1'b1; tick(1); cap_clk = 1'b0; tick(1);
        for (int j = 0; j < L; j++) begin
            view(j);
            check("R3 edge with ce high ignored", out_data, pat(3, j));
        end

        // R2: enabled edge loads pattern 5
        s1_ce_n = 1'b0;
        cap_clk = 1'b1; tick(1);
        // R8: keep cap high, change lanes, no further load
        lane_data = pack(6);
        tick(3);
        for (int j = 0; j < L; j++) begin
            view(j);
            check("R2 load on edge", out_data, pat(5, j));
        end
        for (int j = 0; j < L; j++) begin
            view(j);
            check("R8 held level no reload", out_data, pat(5, j));
        end
        cap_clk = 1'b0; tick(1);
        cap_clk = 1'b1; tick(1);
        cap_clk = 1'b0; lane_data = pack(7);
        for (int j = 0; j < L; j++) begin
            view(j);
            check("R8 R2 second edge loads", out_data, pat(6, j));
        end
        // state: stage 1 holds pattern 6

        // R1: one lane enabled at a time
        s1_ce_n = 1'b1;
        for (int i = 0; i < L; i++) begin
            lane_le = L'(1 << i);
            lane_data = pack(8 + i);
            tick(2);
            lane_le = '0;
            tick(1);
            for (int j = 0; j < L; j++) begin
                view(j);
                check($sformatf("R1 lane %0d enable, view %0d", i, j), out_data,
                      (j <= i) ? pat(8 + j, j) : pat(6, j));
            end
        end
        // state: lane j holds pat(8+j, j)

        // R6: second stage holds when its clock enable is high
        sel = 2'd0; tick(1);
        s2_le = 1'b0; s2_ce_n = 1'b1;
        lane_le = '1; lane_data = pack(12);
        tick(3);
        check("R6 hold without edge", out_data, pat(8, 0));
        cap_clk = 1'b1; tick(1); cap_clk = 1'b0; tick(1);
        check("R6 hold with ce high edge", out_data, pat(8, 0));
        s2_ce_n = 1'b0;
        cap_clk = 1'b1; tick(1);
        check("R6 load on enabled edge", out_data, pat(12, 0));
        cap_clk = 1'b0; tick(1);

        // R10: one edge loads both stages, second gets old first-stage value
        lane_le = '0; s1_ce_n = 1'b0; sel = 2'd1;
        lane_data = pack(13);
        tick(1);
        cap_clk = 1'b1; tick(1);
        check("R10 shared edge takes old value", out_data, pat(12, 1));
        cap_clk = 1'b0; tick(1);
        cap_clk = 1'b1; tick(1);
        check("R10 next edge takes new value", out_data, pat(13, 1));
        cap_clk = 1'b0; tick(1);

        // R7: output enable
        oe_n = 1'b1; #1;
        check_bit("R7 released flag", out_en, 1'b0);
        check("R7 released data", out_data, '0);
        oe_n = 1'b0; #1;
        check_bit("R7 driven flag", out_en, 1'b1);
        check("R7 driven data", out_data, pat(13, 1));
        @(negedge clk);

        // R9: reset mid-run with cap held high gives no spurious edge
        cap_clk = 1'b1; rst = 1'b1; tick(1);
        rst = 1'b0; s2_le = 1'b1; lane_data = pack(14);
        tick(2);
        for (int j = 0; j < L; j++) begin
            view(j);
            check("R9 cleared and no edge after reset", out_data, '0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule